// File: doc/BRIEF.md
# Ring Count Range Extender with Gate Control

This block sits between a bank of 16-bit wrapping hardware pulse counters and the logic that consumes a position or event count. One channel is chosen from the bank when a run starts. The block follows that channel's raw value and turns it into a signed count that is either 16 or 32 bits wide. The count is always presented sign-extended on a 32-bit output. Both widths behave as a ring: passing the positive maximum lands on the negative maximum, and the reverse, with no overflow indication.

The block also commands the counter. It drives the counter's enable, its clear and its pulse-decoding mode. It starts a run with a clear followed by an initialisation-done flag. A clear command zeroes the count and is acknowledged. An optional gate mode lets an external gate signal switch the counter enable. The configuration word is taken only when a run starts, so rewriting it during a run has no effect. The counting and direction status of the chosen channel are passed straight through.

Top module: `rgx_extender`

## Requirements
- R1: The configuration word `cfg_i` (bits [1:0] pulse mode, bit 2 width select with 1 meaning 32-bit, bit 3 gate-mode enable) and `chan_sel_i` are taken only on the clock edge at which `start_i` is first seen high; later changes during the run leave `cnt_mode_o`, the output width and the gate behaviour unchanged.
- R2: On the start edge, `cnt_clr_o` is high for exactly the following cycle. `init_done_o` rises two cycles after that with `count_o` equal to 0, and it falls one cycle after `start_i` goes low.
- R3: The captured pulse mode is presented on `cnt_mode_o`. Mode code 2'b11 holds `cnt_en_o` low, and codes 2'b00, 2'b01 and 2'b10 allow counting.
- R4: In 16-bit mode, `count_o` is the low 16 bits of the accumulated count, sign-extended, so it runs from -32768 to 32767 and steps from 32767 to -32768 with no flag.
- R5: In 32-bit mode, `count_o` uses the full signed 32-bit range and steps from 2147483647 to -2147483648 with no flag.
- R6: While running, each cycle adds to the count the signed 16-bit difference between the selected channel's current raw value and its value one cycle earlier. A raw step of +N or -N with |N| < 32768 changes the count by exactly that amount in the cycle after it is sampled.
- R7: With gate mode off, `cnt_en_o` is held high while running in a counting mode. With gate mode on, `cnt_en_o` equals `gate_i` combinationally while running.
- R8: `cnt_clr_o` is high in the cycle after `clr_cmd_i` is sampled high. One cycle later `count_o` is 0 and `clr_ack_o` is high. `clr_ack_o` falls two cycles after `clr_cmd_i` is sampled low.
- R9: The channel index captured at start selects which 16-bit slice of `cnt_raw_i` is followed (channel k at bits [16k+15:16k]). `counting_o` and `dir_o` equal that channel's bits of `cnt_busy_i` and `cnt_dir_i` combinationally.
- R10: Outside a run (before start and after `start_i` falls), `cnt_en_o` is low and `count_o` holds its value whatever the raw input does.
- R11: After reset, all outputs are low and `count_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cnt_raw_i | input | 64 | Raw 16-bit values of the four counter channels |
| cnt_busy_i | input | 4 | Per-channel counting status from the counters |
| cnt_dir_i | input | 4 | Per-channel direction status (1 = reverse) |
| start_i | input | 1 | Run command; its rising edge captures configuration |
| clr_cmd_i | input | 1 | Count clear command |
| gate_i | input | 1 | Gate used when gate mode is on |
| chan_sel_i | input | 2 | Channel index to follow |
| cfg_i | input | 4 | Configuration word (mode, width, gate enable) |
| cnt_en_o | output | 1 | Enable to the counter |
| cnt_clr_o | output | 1 | Clear to the counter |
| cnt_mode_o | output | 2 | Pulse decoding mode to the counter |
| count_o | output | 32 | Sign-extended extended count |
| counting_o | output | 1 | Selected channel counting status |
| dir_o | output | 1 | Selected channel direction status |
| init_done_o | output | 1 | Run initialised after start clear |
| clr_ack_o | output | 1 | Acknowledge of the clear command |

## Verification
A corrupted previous-raw register shows up on `count_o` as a jump in the cycle right after the next sample, so the table walk compares the count on every step. Corrupted configuration state appears at once on `cnt_mode_o`, on the sign extension of `count_o` or on whether `cnt_en_o` follows `gate_i`. A rewrite of the configuration in the middle of a run is followed by a raw step whose result differs between the two widths. A phase register stuck in the wrong state either delays `init_done_o` past its two-cycle slot or leaves `cnt_en_o` high outside a run, and a long climb through 2^31 shows whether the wide accumulator carries.

// File: rtl/rgx_pkg.sv
package rgx_pkg;

  typedef enum logic [1:0] {
    PM_QUAD  = 2'b00,
    PM_UPDN  = 2'b01,
    PM_PSIGN = 2'b10,
    PM_HOLD  = 2'b11
  } pmode_e;

  typedef struct packed {
    logic   gate_en;
    logic   wide;
    pmode_e mode;
  } cfg_t;

  typedef enum logic [1:0] {
    PH_IDLE = 2'b00,
    PH_CLR  = 2'b01,
    PH_SYNC = 2'b10,
    PH_RUN  = 2'b11
  } phase_e;

endpackage

// File: rtl/rgx_rst_sync.sv
module rgx_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic arst_ni,
  output logic rst_no
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk_i or negedge arst_ni) begin
    if (!arst_ni) sync_q <= '0;
    else          sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_no = sync_q[STAGES-1];
endmodule

// File: rtl/rgx_ctrl.sv
module rgx_ctrl
  import rgx_pkg::*;
#(
  parameter int NCH  = 4,
  parameter int SELW = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic            clr_cmd_i,
  input  logic            gate_i,
  input  cfg_t            cfg_i,
  input  logic [SELW-1:0] sel_i,
  output cfg_t            cfg_o,
  output logic [SELW-1:0] sel_o,
  output logic            zero_o,
  output logic            acc_en_o,
  output logic            en_o,
  output logic            clr_o,
  output logic            init_done_o,
  output logic            ack_o
);
  localparam logic [SELW:0] NCH_L = NCH[SELW:0];

  logic            start_q;
  phase_e          phase_q, phase_d;
  cfg_t            cfg_q;
  logic [SELW-1:0] sel_q;
  logic            rcmd_q, ack_q;
  logic            start_rise, sel_ok;

  assign start_rise = start_i & ~start_q;
  assign sel_ok     = ({1'b0, sel_i} < NCH_L);

  // next phase
  always_comb begin
    phase_d = phase_q;
    if (!start_i) begin
      phase_d = PH_IDLE;
    end else if (start_rise) begin
      phase_d = PH_CLR;
    end else begin
      case (phase_q)
        PH_CLR:  phase_d = PH_SYNC;
        PH_SYNC: phase_d = PH_RUN;
        PH_RUN:  phase_d = PH_RUN;
        default: phase_d = PH_IDLE;
      endcase
    end
  end

  // registers
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      start_q <= 1'b0;
      phase_q <= PH_IDLE;
      cfg_q   <= '0;
      sel_q   <= '0;
      rcmd_q  <= 1'b0;
      ack_q   <= 1'b0;
    end else begin
      start_q <= start_i;
      phase_q <= phase_d;
      rcmd_q  <= clr_cmd_i;
      ack_q   <= rcmd_q;
      if (start_rise) begin
        cfg_q <= cfg_i;
        if (sel_ok) sel_q <= sel_i;
      end
    end
  end

  assign cfg_o       = cfg_q;
  assign sel_o       = sel_q;
  assign init_done_o = (phase_q == PH_RUN);
  assign clr_o       = (phase_q == PH_CLR) | rcmd_q;
  assign zero_o      = (phase_q == PH_CLR) | (phase_q == PH_SYNC) | rcmd_q;
  assign acc_en_o    = (phase_q == PH_RUN) & ~rcmd_q;
  assign en_o        = (phase_q == PH_RUN) & ~rcmd_q & (cfg_q.mode != PM_HOLD)
                     & (~cfg_q.gate_en | gate_i);
  assign ack_o       = ack_q;
endmodule

// File: rtl/rgx_accum.sv
module rgx_accum #(
  parameter int CW = 16,
  parameter int OW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [CW-1:0] raw_i,
  input  logic          acc_en_i,
  input  logic          zero_i,
  input  logic          wide_i,
  output logic [OW-1:0] count_o
);
  localparam int XW = OW - CW;

  logic [CW-1:0] prev_q;
  logic [OW-1:0] ext_q, ext_d;
  logic [CW-1:0] delta;

  assign delta = raw_i - prev_q;

  always_comb begin
    ext_d = ext_q;
    if (zero_i)        ext_d = '0;
    else if (acc_en_i) ext_d = ext_q + {{XW{delta[CW-1]}}, delta};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= '0;
      ext_q  <= '0;
    end else begin
      prev_q <= raw_i;
      ext_q  <= ext_d;
    end
  end

  assign count_o = wide_i ? ext_q : {{XW{ext_q[CW-1]}}, ext_q[CW-1:0]};
endmodule

// File: rtl/rgx_extender.sv
module rgx_extender
  import rgx_pkg::*;
#(
  parameter int NCH  = 4,
  parameter int CW   = 16,
  parameter int OW   = 32,
  parameter int SELW = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NCH*CW-1:0] cnt_raw_i,
  input  logic [NCH-1:0]    cnt_busy_i,
  input  logic [NCH-1:0]    cnt_dir_i,
  input  logic              start_i,
  input  logic              clr_cmd_i,
  input  logic              gate_i,
  input  logic [SELW-1:0]   chan_sel_i,
  input  logic [3:0]        cfg_i,
  output logic              cnt_en_o,
  output logic              cnt_clr_o,
  output logic [1:0]        cnt_mode_o,
  output logic [OW-1:0]     count_o,
  output logic              counting_o,
  output logic              dir_o,
  output logic              init_done_o,
  output logic              clr_ack_o
);
  logic            rst_n;
  cfg_t            cfg_in, cfg_q;
  logic [SELW-1:0] sel_q;
  logic            zero, acc_en;
  logic [CW-1:0]   raw_sel;
  logic            bsy_sel, dir_sel;
  logic            wide_sel, gate_sel;

  assign cfg_in = cfg_t'(cfg_i);

  rgx_rst_sync #(.STAGES(2)) u_rst (
    .clk_i  (clk_i),
    .arst_ni(rst_ni),
    .rst_no (rst_n)
  );

  rgx_ctrl #(.NCH(NCH), .SELW(SELW)) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_n),
    .start_i    (start_i),
    .clr_cmd_i  (clr_cmd_i),
    .gate_i     (gate_i),
    .cfg_i      (cfg_in),
    .sel_i      (chan_sel_i),
    .cfg_o      (cfg_q),
    .sel_o      (sel_q),
    .zero_o     (zero),
    .acc_en_o   (acc_en),
    .en_o       (cnt_en_o),
    .clr_o      (cnt_clr_o),
    .init_done_o(init_done_o),
    .ack_o      (clr_ack_o)
  );

  // channel mux
  always_comb begin
    raw_sel = '0;
    bsy_sel = 1'b0;
    dir_sel = 1'b0;
    for (int i = 0; i < NCH; i++) begin
      if (sel_q == i[SELW-1:0]) begin
        raw_sel = cnt_raw_i[i*CW +: CW];
        bsy_sel = cnt_busy_i[i];
        dir_sel = cnt_dir_i[i];
      end
    end
  end

  assign wide_sel = cfg_q.wide;
  assign gate_sel = cfg_q.gate_en;

  rgx_accum #(.CW(CW), .OW(OW)) u_acc (
    .clk_i   (clk_i),
    .rst_ni  (rst_n),
    .raw_i   (raw_sel),
    .acc_en_i(acc_en),
    .zero_i  (zero),
    .wide_i  (wide_sel),
    .count_o (count_o)
  );

  assign cnt_mode_o = cfg_q.mode;
  assign counting_o = bsy_sel;
  assign dir_o      = dir_sel;
endmodule

// File: rtl/rgx_checker.sv
module rgx_checker #(
  parameter int OW = 32
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          clr_cmd_i,
  input logic          gate_i,
  input logic          cnt_en_o,
  input logic          cnt_clr_o,
  input logic [1:0]    cnt_mode_o,
  input logic [OW-1:0] count_o,
  input logic          init_done_o,
  input logic          clr_ack_o,
  input logic          wide_sel,
  input logic          gate_sel
);
  a_r1_cfg_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (init_done_o && $past(init_done_o)) |-> $stable(cnt_mode_o));

  a_r2_init_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(init_done_o) |-> (count_o == '0));

  a_r2_clr_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(init_done_o) |-> $past(cnt_clr_o, 2));

  a_r3_hold_mode: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_mode_o == 2'b11) |-> !cnt_en_o);

  a_r4_narrow_sext: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wide_sel |-> (count_o[OW-1:15] == '0 || count_o[OW-1:15] == '1));

  a_r7_gate_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gate_sel && !gate_i) |-> !cnt_en_o);

  a_r8_clr_out: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(clr_cmd_i) |-> cnt_clr_o);

  a_r8_zero_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(clr_cmd_i, 2) && $past(clr_cmd_i)) |-> (count_o == '0 && clr_ack_o));

  a_r10_idle_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !init_done_o |-> !cnt_en_o);
endmodule

bind rgx_extender rgx_checker #(.OW(OW)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .clr_cmd_i  (clr_cmd_i),
  .gate_i     (gate_i),
  .cnt_en_o   (cnt_en_o),
  .cnt_clr_o  (cnt_clr_o),
  .cnt_mode_o (cnt_mode_o),
  .count_o    (count_o),
  .init_done_o(init_done_o),
  .clr_ack_o  (clr_ack_o),
  .wide_sel   (wide_sel),
  .gate_sel   (gate_sel)
);

// File: tb/rgx_extender_tb.sv
module rgx_extender_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [63:0] raw_bus;
  logic [3:0]  busy, dirs;
  logic        start, clr_cmd, gate;
  logic [1:0]  sel;
  logic [3:0]  cfg;
  logic        en, clr, init_done, ack, counting, dir;
  logic [1:0]  mode;
  logic [31:0] count;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  rgx_extender u_dut (
    .clk_i(clk), .rst_ni(rst_n), .cnt_raw_i(raw_bus), .cnt_busy_i(busy),
    .cnt_dir_i(dirs), .start_i(start), .clr_cmd_i(clr_cmd), .gate_i(gate),
    .chan_sel_i(sel), .cfg_i(cfg), .cnt_en_o(en), .cnt_clr_o(clr),
    .cnt_mode_o(mode), .count_o(count), .counting_o(counting), .dir_o(dir),
    .init_done_o(init_done), .clr_ack_o(ack)
  );

  // raw, expected in 16-bit mode, expected in 32-bit mode
  localparam int NV = 11;
  localparam logic [79:0] VEC [NV] = '{
    {16'h0064,  32'sd100,    32'sd100},
    {16'hFFF0, -32'sd16,    -32'sd16},
    {16'h3000,  32'sd12288,  32'sd12288},
    {16'h6000,  32'sd24576,  32'sd24576},
    {16'h7FFF,  32'sd32767,  32'sd32767},
    {16'h8000, -32'sd32768,  32'sd32768},
    {16'hB000, -32'sd20480,  32'sd45056},
    {16'hF000, -32'sd4096,   32'sd61440},
    {16'h1000,  32'sd4096,   32'sd69632},
    {16'h0000,  32'sd0,      32'sd65536},
    {16'hE000, -32'sd8192,   32'sd57344}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic set_raw(input int ch, input logic [15:0] v);
    raw_bus[ch*16 +: 16] = v;
  endtask

  task automatic start_run(input logic [3:0] c, input logic [1:0] s);
    cfg = c; sel = s; set_raw(s, 16'h0000); start = 1'b1;
    @(negedge clk);
    check("R2 clear pulse", {31'd0, clr}, 32'd1);
    @(negedge clk);
    check("R2 clear single cycle", {31'd0, clr}, 32'd0);
    check("R2 init not yet", {31'd0, init_done}, 32'd0);
    @(negedge clk);
    check("R2 init done", {31'd0, init_done}, 32'd1);
    check("R2 count zero", count, 32'd0);
  endtask

  task automatic stop_run();
    start = 1'b0;
    @(negedge clk);
    check("R2 init falls", {31'd0, init_done}, 32'd0);
    check("R10 enable off", {31'd0, en}, 32'd0);
  endtask

  task automatic walk(input int ch, input bit wide);
    for (int i = 0; i < NV; i++) begin
      logic [79:0] v;
      v = VEC[i];
      set_raw(ch, v[79:64]);
      @(negedge clk);
      if (wide) check("R5 R6 wide step", count, v[31:0]);
      else      check("R4 R6 narrow step", count, v[63:32]);
    end
  endtask

  initial begin
    #1_500_000;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    end
    $finish;
  end

  initial begin
    rst_n = 1'b0; raw_bus = '0; busy = '0; dirs = '0;
    start = 0; clr_cmd = 0; gate = 0; sel = 0; cfg = 0;
    repeat (3) @(negedge clk);
    check("R11 reset count", count, 32'd0);
    check("R11 reset outputs", {26'd0, en, clr, mode, init_done, ack}, 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R10 before any run
    set_raw(1, 16'h1234);
    @(negedge clk);
    check("R10 idle count hold", count, 32'd0);
    check("R10 idle enable", {31'd0, en}, 32'd0);

    // narrow, quadrature, no gate, channel 1
    start_run(4'b0000, 2'd1);
    check("R3 mode out quad", {30'd0, mode}, 32'd0);
    check("R7 gate off enable", {31'd0, en}, 32'd1);
    walk(1, 1'b0);

    // R8 clear command
    clr_cmd = 1'b1;
    @(negedge clk);
    check("R8 clear out", {31'd0, clr}, 32'd1);
    set_raw(1, 16'h0000);
    @(negedge clk);
    check("R8 count zeroed", count, 32'd0);
    check("R8 ack high", {31'd0, ack}, 32'd1);
    clr_cmd = 1'b0;
    repeat (2) @(negedge clk);
    check("R8 ack falls", {31'd0, ack}, 32'd0);
    set_raw(1, 16'h0123);
    @(negedge clk);
    check("R6 step after clear", count, 32'd291);

    // R10 after stop
    stop_run();
    set_raw(1, 16'h5555);
    repeat (2) @(negedge clk);
    check("R10 stopped count hold", count, 32'd291);

    // wide, up/down mode, gate on, channel 2
    gate = 1'b0;
    start_run(4'b1101, 2'd2);
    check("R3 mode out updn", {30'd0, mode}, 32'd1);
    check("R7 gate low", {31'd0, en}, 32'd0);
    gate = 1'b1; #1;
    check("R7 gate high", {31'd0, en}, 32'd1);
    busy = 4'b0100; dirs = 4'b0100; #1;
    check("R9 counting pass", {31'd0, counting}, 32'd1);
    check("R9 dir pass", {31'd0, dir}, 32'd1);
    busy = 4'b1011; dirs = 4'b1011; #1;
    check("R9 other channels", {30'd0, counting, dir}, 32'd0);
    set_raw(1, 16'h7777);
    walk(2, 1'b1);

    // R1 rewrite config mid-run: narrow, hold mode, gate off
    cfg = 4'b0011;
    gate = 1'b0;
    set_raw(2, 16'h0000);
    @(negedge clk);
    check("R1 mode kept", {30'd0, mode}, 32'd1);
    check("R1 width kept", count, 32'd65536);
    check("R1 gate kept", {31'd0, en}, 32'd0);
    stop_run();

    // R3 inhibit mode
    start_run(4'b0011, 2'd0);
    check("R3 mode out hold", {30'd0, mode}, 32'd3);
    check("R3 hold enable", {31'd0, en}, 32'd0);
    stop_run();

    // R5 long climb through 2^31
    start_run(4'b0100, 2'd0);
    begin
      logic [15:0] r;
      logic [31:0] e;
      int bad;
      bit wrapped;
      r = 16'h0000; e = 32'd0; bad = 0; wrapped = 0;
      for (int i = 0; i < 65540; i++) begin
        r = r + 16'h7FFF;
        e = e + 32'd32767;
        set_raw(0, r);
        @(negedge clk);
        if (count !== e) bad++;
        if (e[31] && count === e) wrapped = 1;
      end
      check("R5 long climb mismatches", bad, 32'd0);
      check("R5 reached negative side", {31'd0, wrapped}, 32'd1);
    end
    stop_run();

    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    end
    $finish;
  end
endmodule